// File: doc/BRIEF.md
# Main Clock Source Selector and Divider

This block picks one of four clock sources as the main clock and divides it down to the clock that feeds the core and peripherals. Software programs a staged source select, then commits it with a low-to-high sequence on a separate update bit. The change-over is glitch-free. The output of the old source is first parked low on that source's own clock. Only then is the new source released, on its own clock. The switch starts only when the status inputs mark both sources as running. Until the switch completes, a pending flag stays readable.

After the source mux sits an 8-bit integer divider. A value of zero holds the output low. A value of one passes the selected clock through unchanged. Any value from 2 to 255 divides by that value. A small synchronous register port on the control clock writes and reads the settings.

Register map (8-bit data):
- Address 0 holds the staged source select in bits [1:0].
- Address 1 holds the update bit in bit 0.
- Address 2 holds the divide value in bits [7:0].
- Address 3 is a read-only status: bits [1:0] give the active source and bit 2 is the pending flag.

Source codes:
- 0 is the internal RC clock.
- 1 is the PLL input clock.
- 2 is the watchdog oscillator clock.
- 3 is the PLL output clock.

Top module: `clk_src_sel_div`

## Requirements
- R1: After reset the select register reads 0, the update bit reads 0, the divider reads 1, and the status reads active source 0 with pending 0; clk_o follows source 0 undivided.
- R2: Writing address 0 alone changes neither the active source (status bits [1:0]) nor the clock on clk_o; the written value reads back from address 0.
- R3: A write of 1 to address 1 bit 0 while that bit holds 0 commits the staged select; a write of 1 while it already holds 1 commits nothing.
- R4: Source code k selects src_clk_i[k] (0 internal RC, 1 PLL input, 2 watchdog oscillator, 3 PLL output); once the switch completes, status bits [1:0] read k and clk_o follows that clock.
- R5: A switch begins only when src_run_i is high for both the old and the new source. Until then status bit 2 (pending) reads 1 and clk_o keeps following the old source. Once both are running, the switch completes and pending returns to 0.
- R6: During a switch, no high or low phase on clk_o is shorter than the shortest half period of the two clocks involved, and at most one source gate is open at any time.
- R7: A divide value of 0 holds clk_o low with no rising edges.
- R8: A divide value of 1 passes the selected clock to clk_o unchanged in period and duty.
- R9: A divide value N from 2 to 255 gives a clk_o period of N source cycles, with a high phase of floor(N/2) source cycles.
- R10: The divide value written to address 2 reads back unchanged from address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register port and switch-control clock |
| rst_ni | input | 1 | Active-low asynchronous reset for all domains |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational from rd_addr_i |
| src_clk_i | input | 4 | Candidate clocks, indexed by source code |
| src_run_i | input | 4 | Per-source running indication |
| clk_o | output | 1 | Divided main clock |

## Verification
The assertions assume the following about the inputs:
- src_run_i is high only for a clock that is actually toggling.
- A source that takes part in a switch keeps running until the switch completes.
- The divide value stays constant while its cross into the main clock domain settles.

The bench keeps within these assumptions:
- It stops a source clock only while that source is neither active nor the target of a switch, and it lowers its running flag first.
- It changes the divide value only between measurements, and it discards the first output periods after each change.
- It arms the narrow-pulse monitor only during source switches, with the divide value held.

// File: rtl/clk_sel_pkg.sv
`timescale 1ns/1ps
package clk_sel_pkg;
  localparam logic [1:0] ADDR_SEL  = 2'd0;
  localparam logic [1:0] ADDR_UEN  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_DROP,
    SW_RAISE
  } sw_state_e;
endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_ON      = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  logic req_s;
  logic en_q;

  cdc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(RST_ON)) i_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // enable moves only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_ON;
    else         en_q <= req_s;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clk_sel_ctrl.sv
`timescale 1ns/1ps
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DIV_W-1:0]   wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [DIV_W-1:0]   rd_data_o,
  input  logic [NUM_SRC-1:0] run_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [DIV_W-1:0]   div_o
);
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  logic [SEL_W-1:0]   sel_q, tgt_q, cur_q, nsel_q;
  logic               uen_q;
  logic [DIV_W-1:0]   div_q;
  logic [NUM_SRC-1:0] req_q, run_s, ack_s;
  logic               pending;
  logic               commit;
  sw_state_e          st_q;

  cdc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES), .RST('0)) i_run_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(run_i), .q_o(run_s)
  );
  cdc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES), .RST(ONE)) i_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  assign commit  = wr_en_i && (wr_addr_i == ADDR_UEN) && wr_data_i[0] && !uen_q;
  assign pending = (tgt_q != cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      uen_q <= 1'b0;
      div_q <= DIV_W'(1);
      tgt_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_SEL: sel_q <= wr_data_i[SEL_W-1:0];
        ADDR_UEN: begin
          uen_q <= wr_data_i[0];
          if (commit) tgt_q <= sel_q;
        end
        ADDR_DIV: div_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  // break-before-make: close old gate, wait for its ack, then open new one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SW_IDLE;
      cur_q  <= '0;
      nsel_q <= '0;
      req_q  <= ONE;
    end else begin
      case (st_q)
        SW_IDLE: if (pending && run_s[cur_q] && run_s[tgt_q]) begin
          nsel_q <= tgt_q;
          req_q  <= '0;
          st_q   <= SW_DROP;
        end
        SW_DROP: if (!ack_s[cur_q]) begin
          req_q <= ONE << nsel_q;
          st_q  <= SW_RAISE;
        end
        SW_RAISE: if (ack_s[nsel_q]) begin
          cur_q <= nsel_q;
          st_q  <= SW_IDLE;
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_SEL:  rd_data_o = DIV_W'(sel_q);
      ADDR_UEN:  rd_data_o = DIV_W'(uen_q);
      ADDR_DIV:  rd_data_o = div_q;
      default:   rd_data_o = DIV_W'({pending, cur_q});
    endcase
  end

  assign req_o = req_q;
  assign div_o = div_q;

  assert_gate_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_s));

  assert_active_acked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> ack_s[cur_q]);

  assert_sel_staged_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_SEL) |=> $stable(tgt_q));

  assert_repeat_uen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_UEN && uen_q) |=> $stable(tgt_q));
endmodule

// File: rtl/clk_int_div.sv
`timescale 1ns/1ps
module clk_int_div #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] div_s, cnt_q, cnt_n, half, last;
  logic             q_q, byp_q;

  cdc_sync #(.W(DIV_W), .STAGES(SYNC_STAGES), .RST(DIV_W'(1))) i_div_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(div_i), .q_o(div_s)
  );

  assign half = div_s >> 1;
  assign last = div_s - DIV_W'(1);

  always_comb begin
    if (div_s < DIV_W'(2) || cnt_q >= last) cnt_n = '0;
    else                                   cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      q_q   <= (div_s >= DIV_W'(2)) && (cnt_n < half);
    end
  end

  // bypass select changes only while the input is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b1;
    else         byp_q <= (div_s == DIV_W'(1));
  end

  assign clk_o = (clk_i & byp_q) | q_q;

  assert_zero_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_s == '0) |=> !q_q);

  assert_no_bypass_when_div_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_s) >= DIV_W'(2) && $stable(div_s)) |-> !byp_q);
endmodule

// File: rtl/clk_src_sel_div.sv
`timescale 1ns/1ps
module clk_src_sel_div #(
  parameter int NUM_SRC     = 4,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DIV_W-1:0]   wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [DIV_W-1:0]   rd_data_o,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic [NUM_SRC-1:0] src_run_i,
  output logic               clk_o
);
  logic [NUM_SRC-1:0] req, en, gclk;
  logic [DIV_W-1:0]   div;
  logic               main_clk;

  clk_sel_ctrl #(
    .NUM_SRC(NUM_SRC), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .run_i    (src_run_i),
    .ack_i    (en),
    .req_o    (req),
    .div_o    (div)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .RST_ON(g == 0)) i_gate (
      .clk_i (src_clk_i[g]),
      .rst_ni(rst_ni),
      .req_i (req[g]),
      .en_o  (en[g]),
      .gclk_o(gclk[g])
    );
  end

  assign main_clk = |gclk;

  clk_int_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) i_div (
    .clk_i (main_clk),
    .rst_ni(rst_ni),
    .div_i (div),
    .clk_o (clk_o)
  );
endmodule

// File: tb/test_clk_src_sel_div.sv
`timescale 1ns/1ps
module test_clk_src_sel_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] sclk = '0;
  logic [3:0] run = 4'hf;
  logic       clk_o;

  int tests = 0;
  int failed = 0;
  int glitches = 0;
  int edges = 0;
  bit mon_on = 1'b0;
  realtime last_t = 0.0;

  // half periods in ns: sources 0..3 = 15, 23, 35, 7
  real half_ns [4] = '{15.0, 23.0, 35.0, 7.0};

  clk_src_sel_div i_clk_src_sel_div (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .src_clk_i(sclk),
    .src_run_i(run),
    .clk_o    (clk_o)
  );

  always #10 clk = ~clk;
  always begin #15; if (run[0]) sclk[0] = ~sclk[0]; end
  always begin #23; if (run[1]) sclk[1] = ~sclk[1]; end
  always begin #35; if (run[2]) sclk[2] = ~sclk[2]; end
  always begin #7;  if (run[3]) sclk[3] = ~sclk[3]; end

  always @(clk_o) begin
    if (mon_on && ($realtime - last_t) < 6.99) glitches++;
    last_t = $realtime;
  end
  always @(posedge clk_o) edges++;

  initial begin
    #3_000_000;
    failed++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  task automatic chk_int(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_real(input string req, input real act, input real exp);
    tests++;
    if (act - exp > 0.05 || exp - act > 0.05) begin
      failed++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output real per, output real hi);
    realtime t0, t1, t2;
    @(posedge clk_o); @(posedge clk_o); @(posedge clk_o);
    t0 = $realtime;
    @(negedge clk_o);
    t1 = $realtime;
    @(posedge clk_o);
    t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic wait_settled();
    int v;
    for (int k = 0; k < 1000; k++) begin
      rd(2'd3, v);
      if (((v >> 2) & 1) == 0) break;
    end
  endtask

  task automatic commit();
    wr(2'd1, 8'd0);
    wr(2'd1, 8'd1);
  endtask

  task automatic check_src(input string req, input int src);
    real per, hi;
    measure(per, hi);
    chk_real({req, " period"}, per, 2.0 * half_ns[src]);
    chk_real({req, " high"}, hi, half_ns[src]);
  endtask

  initial begin
    int v;
    real per, hi;
    int div_list [43];
    for (int k = 0; k < 39; k++) div_list[k] = k + 2;
    div_list[39] = 64; div_list[40] = 100; div_list[41] = 254; div_list[42] = 255;

    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    rd(2'd0, v); chk_int("R1 sel reset", v, 0);
    rd(2'd1, v); chk_int("R1 uen reset", v, 0);
    rd(2'd2, v); chk_int("R1 div reset", v, 1);
    rd(2'd3, v); chk_int("R1 status reset", v, 0);
    check_src("R1 clk_o src0", 0);

    // R2 staged select alone does nothing
    wr(2'd0, 8'd3);
    idle(40);
    rd(2'd0, v); chk_int("R2 sel readback", v, 3);
    rd(2'd3, v); chk_int("R2 status unchanged", v, 0);
    check_src("R2 clk_o still src0", 0);

    // R3 / R4 commit to PLL output
    mon_on = 1'b1;
    commit();
    wait_settled();
    rd(2'd3, v); chk_int("R3 status after commit", v, 3);
    check_src("R4 clk_o src3", 3);

    // R3 repeated 1 write while already 1
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd1);
    idle(60);
    rd(2'd3, v); chk_int("R3 no commit on repeat", v, 3);
    check_src("R3 clk_o still src3", 3);

    // R4 watchdog oscillator, then internal RC
    commit();
    wait_settled();
    rd(2'd3, v); chk_int("R4 status src2", v, 2);
    check_src("R4 clk_o src2", 2);
    wr(2'd0, 8'd0);
    commit();
    wait_settled();
    rd(2'd3, v); chk_int("R4 status src0", v, 0);
    check_src("R4 clk_o src0", 0);

    // R5 target not running: parked with pending
    run[1] = 1'b0;
    idle(10);
    wr(2'd0, 8'd1);
    commit();
    idle(150);
    rd(2'd3, v); chk_int("R5 pending parked", v, 4);
    check_src("R5 clk_o still src0", 0);
    run[1] = 1'b1;
    wait_settled();
    rd(2'd3, v); chk_int("R5 status after run", v, 1);
    check_src("R5 clk_o src1", 1);

    wr(2'd0, 8'd3);
    commit();
    wait_settled();
    rd(2'd3, v); chk_int("R4 status back to src3", v, 3);
    idle(20);
    mon_on = 1'b0;
    chk_int("R6 narrow pulses", glitches, 0);

    // R7 divide by zero
    wr(2'd2, 8'd0);
    idle(20);
    edges = 0;
    idle(100);
    chk_int("R7 edges with div 0", edges, 0);
    chk_int("R7 level with div 0", int'(clk_o), 0);

    // R8 pass-through
    wr(2'd2, 8'd1);
    idle(20);
    check_src("R8 div 1", 3);

    // R9 divide sweep
    foreach (div_list[k]) begin
      wr(2'd2, 8'(div_list[k]));
      idle(10);
      measure(per, hi);
      chk_real($sformatf("R9 period div %0d", div_list[k]), per, 14.0 * div_list[k]);
      chk_real($sformatf("R9 high div %0d", div_list[k]), hi, 14.0 * (div_list[k] / 2));
    end

    // R10 readback
    rd(2'd2, v); chk_int("R10 div readback", v, 255);
    wr(2'd2, 8'd170);
    rd(2'd2, v); chk_int("R10 div readback 170", v, 170);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule